// File: doc/BRIEF.md
# Dual-Clock Latched Serial-to-Parallel Register

This block gathers a serial bit stream into a chain of shift stages on one clock. On a second, independent clock it copies the whole chain at once into a holding register, and that register feeds the parallel pins. The parallel pins can therefore stay steady while new data is shifted in behind them. The last shift stage is also brought out as a serial output, so several blocks can be chained end to end.

An asynchronous active-low clear empties the shift stages only. The holding register keeps its value through a clear. An active-low output enable turns the parallel pins off. Each pin is given as a data bit plus a drive-enable bit, so the pad ring can build the high-impedance state. This avoids the need for internal tri-state nets.

When both clocks come from the same edge, the holding register captures the chain as it was just before that edge. The pins then trail the chain by one clock.

Top module: `latched_serial_out`

## Requirements
- R1: On each rising edge of `sclk` with `clr_n` high, `ser_in` enters stage 0 and every stage k>0 takes the old value of stage k-1.
- R2: On each rising edge of `lclk` (outside reset), `pin_d[k]` takes the value of shift stage k, for all k at once.
- R3: While `clr_n` is low, all shift stages are 0 and `ser_out` is 0 at once, without any clock edge.
- R4: A clear leaves `pin_d` unchanged until the next `lclk` edge.
- R5: With `oe_n` low every bit of `pin_en` is 1. With `oe_n` high every bit of `pin_en` is 0, which means all pins are high impedance.
- R6: `ser_out` always equals the last stage (WIDTH-1) and does not depend on `oe_n`. A WIDTH of 16 behaves like two 8-stage units with the serial output of the first wired to the serial input of the second.
- R7: A rising `lclk` edge while `clr_n` is low loads all zeros into `pin_d`.
- R8: When `sclk` and `lclk` rise together, `pin_d` receives the chain contents from before that edge.
- R9: With `STORE_RST` set to 1, a rising `lclk` edge with `rst_n` low sets `pin_d` to 0. With `STORE_RST` set to 0, the holding register is not reset and has no defined start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | shift clock, rising edge active |
| lclk | input | 1 | latch clock for the holding register, rising edge active |
| rst_n | input | 1 | synchronous active-low reset of the holding register (used only when STORE_RST=1) |
| clr_n | input | 1 | asynchronous active-low clear of the shift stages |
| ser_in | input | 1 | serial data into stage 0 |
| oe_n | input | 1 | active-low enable for the parallel pins |
| ser_out | output | 1 | last shift stage, used for cascading |
| pin_d | output | WIDTH | holding register contents, one bit per pin |
| pin_en | output | WIDTH | drive enable per pin; 0 means high impedance |

## Verification
The clock-sampled properties assume that `clr_n` and `ser_in` only change while `sclk` is low. They also assume that a clear is held across at least one `sclk` edge before it is released, so that the property on the shift stages never straddles a clear that comes and goes between edges. The stimulus tasks change inputs only half a period away from any rising edge. The clear task pulses a clock while `clr_n` is low. The assertions on the holding register are disabled during `rst_n`, so the undefined start value with STORE_RST=0 is never examined.

// File: rtl/lsr_pkg.sv
// Package: shared defaults for the latched serial-to-parallel register.
// Assumes: nothing; holds only constants.
package lsr_pkg;
    localparam int LSR_DEF_WIDTH = 8;
    localparam int LSR_MIN_WIDTH = 2;
endpackage

// File: rtl/lsr_shift_chain.sv
// Shift chain: WIDTH stages, serial in at stage 0, async active-low clear.
// Assumes: WIDTH >= 2; din is stable around the rising sclk edge.
module lsr_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             sclk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    // One flop per stage, each loading its lower neighbour.
    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        logic nxt;
        if (k == 0) begin : g_first
            assign nxt = din;
        end else begin : g_rest
            assign nxt = q[k-1];
        end
        // Stage register with asynchronous clear.
        always_ff @(posedge sclk or negedge clr_n) begin
            if (!clr_n) q[k] <= 1'b0;
            else        q[k] <= nxt;
        end
    end
endmodule

// File: rtl/lsr_store.sv
// Holding register: parallel copy of the shift chain on lclk.
// Assumes: d comes from the sclk domain and is settled at the lclk edge.
module lsr_store #(
    parameter int WIDTH     = 8,
    parameter bit STORE_RST = 1'b0
) (
    input  logic             lclk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    if (STORE_RST) begin : g_rst
        // Parallel load, with a synchronous active-low reset to zero.
        always_ff @(posedge lclk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_norst
        logic unused_rst;
        assign unused_rst = rst_n;
        // Parallel load only; the start value is undefined.
        always_ff @(posedge lclk) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lsr_pin_drive.sv
// Pin driver split: data bit plus drive enable per pin, built for pads.
// Assumes: oe_n is active low and common to all pins.
module lsr_pin_drive #(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] store_q,
    output logic [WIDTH-1:0] pin_d,
    output logic [WIDTH-1:0] pin_en
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_pin
        // Forward data and give each pin its own enable.
        always_comb begin
            pin_d[k]  = store_q[k];
            pin_en[k] = ~oe_n;
        end
    end
endmodule

// File: rtl/latched_serial_out.sv
// Top: serial-in shift chain, latched parallel pins, cascade output.
// Assumes: sclk and lclk may be independent or tied together.
module latched_serial_out
    import lsr_pkg::*;
#(
    parameter int WIDTH     = LSR_DEF_WIDTH,
    parameter bit STORE_RST = 1'b0
) (
    input  logic             sclk,
    input  logic             lclk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic             ser_out,
    output logic [WIDTH-1:0] pin_d,
    output logic [WIDTH-1:0] pin_en
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] sh_q;
    logic [WIDTH-1:0] st_q;

    lsr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .sclk (sclk),
        .clr_n(clr_n),
        .din  (ser_in),
        .q    (sh_q)
    );

    lsr_store #(.WIDTH(WIDTH), .STORE_RST(STORE_RST)) u_store (
        .lclk (lclk),
        .rst_n(rst_n),
        .d    (sh_q),
        .q    (st_q)
    );

    lsr_pin_drive #(.WIDTH(WIDTH)) u_pins (
        .oe_n   (oe_n),
        .store_q(st_q),
        .pin_d  (pin_d),
        .pin_en (pin_en)
    );

    // Cascade output is always the last stage.
    assign ser_out = sh_q[LAST];
endmodule

// File: rtl/lsr_checker.sv
// Checker: temporal properties of the latched serial register.
// Assumes: clr_n and ser_in change only while sclk is low.
module lsr_checker #(
    parameter int WIDTH = 8
) (
    input logic             sclk,
    input logic             lclk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             ser_in,
    input logic             oe_n,
    input logic             ser_out,
    input logic [WIDTH-1:0] sh_q,
    input logic [WIDTH-1:0] pin_d,
    input logic [WIDTH-1:0] pin_en
);
    assert_shift_step_R1: assert property (@(posedge sclk) disable iff (!clr_n)
        1'b1 |=> (sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)}));

    assert_latch_copy_R2: assert property (@(posedge lclk) disable iff (!rst_n)
        1'b1 |=> (pin_d == $past(sh_q)));

    assert_clear_out_R3: assert property (@(posedge sclk)
        !clr_n |-> (ser_out == 1'b0));

    assert_oe_off_R5: assert property (@(posedge lclk)
        oe_n |-> (pin_en == '0));

    assert_oe_on_R5: assert property (@(posedge lclk)
        !oe_n |-> (pin_en == '1));

    assert_clear_latch_R7: assert property (@(posedge lclk) disable iff (!rst_n)
        !clr_n |=> (pin_d == '0));
endmodule

bind latched_serial_out lsr_checker #(.WIDTH(WIDTH)) u_lsr_chk (
    .sclk   (sclk),
    .lclk   (lclk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .ser_in (ser_in),
    .oe_n   (oe_n),
    .ser_out(ser_out),
    .sh_q   (sh_q),
    .pin_d  (pin_d),
    .pin_en (pin_en)
);

// File: tb/test_latched_serial_out.sv
module test_latched_serial_out;
    localparam int  W      = 16;
    localparam time PERIOD = 10;
    localparam int  NVEC   = 5;

    // Each vector: word to shift in, oe_n value.
    typedef struct packed { logic [W-1:0] word; logic oe; } vec_t;
    localparam vec_t VECS [NVEC] = '{
        '{16'hA55A, 1'b0}, '{16'h0001, 1'b0}, '{16'h8000, 1'b1},
        '{16'hFFFF, 1'b0}, '{16'h3C96, 1'b1}
    };

    logic sclk = 0, lclk = 0, rst_n = 0, clr_n = 0, ser_in = 0, oe_n = 1;
    logic ser_out;
    logic [W-1:0] pin_d, pin_en;
    logic [W-1:0] m_sh;
    int checks = 0, errors = 0;
    bit done = 0;

    latched_serial_out #(.WIDTH(W), .STORE_RST(1'b1)) i_latched_serial_out (
        .sclk(sclk), .lclk(lclk), .rst_n(rst_n), .clr_n(clr_n),
        .ser_in(ser_in), .oe_n(oe_n), .ser_out(ser_out),
        .pin_d(pin_d), .pin_en(pin_en)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pulse clocks: s=shift, l=latch; inputs already set while low.
    task automatic pulse(input bit s, input bit l);
        #(PERIOD/2);
        if (s) sclk = 1;
        if (l) lclk = 1;
        if (s && clr_n) m_sh = {m_sh[W-2:0], ser_in};
        #(PERIOD/2);
        sclk = 0; lclk = 0;
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int k = W-1; k >= 0; k--) begin
            ser_in = w[k];
            pulse(1, 0);
        end
    endtask

    initial begin
        logic [W-1:0] held;
        m_sh = '0;
        // Reset: rst_n clears holding register on lclk, clear empties chain.
        pulse(1, 1);
        #1;
        chk("R9 reset pins", pin_d, '0);
        chk("R3 reset ser_out", {{(W-1){1'b0}}, ser_out}, '0);
        chk("R5 oe high off", pin_en, '0);
        rst_n = 1; clr_n = 1;

        // Vector table: shift, latch, check pins and enables.
        for (int v = 0; v < NVEC; v++) begin
            oe_n = VECS[v].oe;
            shift_word(VECS[v].word);
            chk("R1 ser_out last stage", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, VECS[v].word[W-1]});
            pulse(0, 1);
            #1;
            chk("R2 latched word", pin_d, VECS[v].word);
            chk("R5 pin enables", pin_en, VECS[v].oe ? '0 : '1);
        end

        // R6: cascade - each further shift reveals the next bit, oe has no effect.
        oe_n = 1;
        shift_word(16'hC3A1);
        for (int k = W-1; k >= W-6; k--) begin
            #1;
            chk("R6 cascade bit", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_sh[W-1]});
            oe_n = ~oe_n;
            ser_in = k[0];
            pulse(1, 0);
        end
        oe_n = 0;

        // R8: tied clocks - pins get pre-edge chain contents.
        shift_word(16'h1234);
        held = m_sh;
        ser_in = 1;
        pulse(1, 1);
        #1;
        chk("R8 tied capture old", pin_d, held);
        ser_in = 0;
        pulse(1, 1);
        #1;
        chk("R8 tied lag one", pin_d, {held[W-2:0], 1'b1});

        // R3/R4: clear empties chain immediately, pins untouched.
        held = pin_d;
        #(PERIOD/2);
        clr_n = 0;
        #1;
        m_sh = '0;
        chk("R3 ser_out zero on clear", {{(W-1){1'b0}}, ser_out}, '0);
        chk("R4 pins hold on clear", pin_d, held);
        // R7: latch while cleared loads zeros.
        pulse(1, 1);
        #1;
        chk("R7 latch zeros", pin_d, '0);
        clr_n = 1;
        // After clear the chain restarts from zero.
        ser_in = 1;
        pulse(1, 0);
        pulse(0, 1);
        #1;
        chk("R1 shift after clear", pin_d, {{(W-1){1'b0}}, 1'b1});

        // R9: synchronous reset of holding register.
        rst_n = 0;
        pulse(0, 1);
        #1;
        chk("R9 sync reset", pin_d, '0);
        rst_n = 1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule